// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register set of a classic byte-wide printer port. A simple bus reaches three registers through the low three address bits: an output data byte, a status byte and a control byte. The printer handshake is modelled inside the block, so no pins are involved. A rising strobe in the control register hands the latched output byte to a valid-only byte stream. Repeated status reads then walk the busy and acknowledge bits through their fixed return sequence.

A control write that pulses strobe low while interrupts are enabled sets an interrupt-pending flag. A status read clears that flag. The level interrupt output follows the flag. Writing the control register with init low forces a fixed "ready" status. An input byte latch, loaded from a side port, is returned on data reads while the direction bit selects input.

Top module: `pp_regif`

## Requirements
- R1: After reset, control reads 0xCC, status reads 0xD9, data reads 0xFF, and the interrupt and stream-valid outputs are 0.
- R2: Only the low three address bits are decoded. Offset 0 is data, 1 is status and 2 is control. Offsets 3 to 7 read 0xFF. Read data appears one cycle after the read.
- R3: A control write stores the written byte with bits 7:6 forced to 1. Control bits are: 0 strobe, 1 auto-feed, 2 init, 3 select, 4 interrupt enable, 5 direction (1 = input).
- R4: A control write with init (bit 2) = 0 sets status to 0xD8. Status bits are: 7 not-busy, 6 ack, 5 paper-out, 4 online, 3 no-error, 0 timeout.
- R5: A control write with init = 1, select = 1 and strobe = 1 clears status bit 7. If the stored strobe was 0, the block also emits the held output byte with a one-cycle valid pulse. If the stored strobe was already 1, nothing is emitted.
- R6: A control write with init = 1, select = 1 and strobe = 0 sets interrupt-pending when the stored control already has interrupt enable = 1. The interrupt output shows the flag from the cycle after the access, and a data write leaves it unchanged.
- R7: A status read returns the status as it was before the read and clears the interrupt output.
- R8: A status read with status bit 7 = 0 and stored strobe = 0 clears ack if ack is set. Otherwise it sets both ack and bit 7.
- R9: A data read returns the input latch when control bit 5 = 1, and the last written data byte when it is 0.
- R10: A control write with init = 1 and select = 0, and any write to the status offset, leave status unchanged and emit nothing.
- R11: A pulse on the load input captures the input byte into the input latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address (low 3 bits decoded) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_load | input | 1 | Capture pulse for the input latch |
| rx_byte | input | 8 | Byte captured into the input latch |
| tx_valid | output | 1 | One-cycle pulse, byte handed out |
| tx_byte | output | 8 | Byte handed out |
| irq | output | 1 | Level interrupt request |

## Verification
Every result of an access is due one rising edge after the edge that accepts it. This covers read data, status and control updates, the interrupt level and the stream pulse. The bench drives each access on a falling edge and removes it on the next falling edge. It samples all outputs at that second falling edge, which lies half a cycle after the edge that updated them. Status is observed only through reads. Because each read returns the value before its own side effect, expected handshake values are chained from one read to the next.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int REG_W = 8;
  localparam int OFS_W = 3;
  typedef logic [REG_W-1:0] reg_t;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STB  = 0;
  localparam int C_AFD  = 1;
  localparam int C_INIT = 2;
  localparam int C_SEL  = 3;
  localparam int C_IEN  = 4;
  localparam int C_DIR  = 5;

  // status bit positions
  localparam int S_TMO   = 0;
  localparam int S_ERRN  = 3;
  localparam int S_ONL   = 4;
  localparam int S_PAPER = 5;
  localparam int S_ACK   = 6;
  localparam int S_BUSYN = 7;

  localparam reg_t CTRL_FIXED = 8'hC0;
  localparam reg_t CTRL_RST   = 8'hCC;
  localparam reg_t STAT_RST   = 8'hD9;
  localparam reg_t STAT_INIT  = 8'hD8;
  localparam reg_t DATA_RST   = 8'hFF;
  localparam reg_t UNMAPPED   = 8'hFF;
endpackage

// File: rtl/pp_ctrl_reg.sv
module pp_ctrl_reg
  import pp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  reg_t wdata,
  output reg_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= CTRL_RST;
    else if (wr) ctrl_q <= wdata | CTRL_FIXED;
  end
endmodule

// File: rtl/pp_status_seq.sv
module pp_status_seq
  import pp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_ctl,
  input  logic wr_dat,
  input  logic rd_sts,
  input  reg_t new_ctl,
  input  reg_t ctrl_q,
  output reg_t status_q,
  output logic irq_o
);
  logic pend_q, pend_n;
  reg_t sts_n;
  logic upd;

  assign upd = wr_ctl | wr_dat | rd_sts;

  always_comb begin
    sts_n  = status_q;
    pend_n = pend_q;
    if (wr_ctl) begin
      if (!new_ctl[C_INIT]) begin
        sts_n = STAT_INIT;
      end else if (new_ctl[C_SEL]) begin
        if (new_ctl[C_STB])       sts_n[S_BUSYN] = 1'b0;
        else if (ctrl_q[C_IEN])   pend_n = 1'b1;
      end
    end else if (rd_sts) begin
      pend_n = 1'b0;
      if (!status_q[S_BUSYN] && !ctrl_q[C_STB]) begin
        if (status_q[S_ACK]) begin
          sts_n[S_ACK] = 1'b0;
        end else begin
          sts_n[S_ACK]   = 1'b1;
          sts_n[S_BUSYN] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= STAT_RST;
      pend_q   <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= sts_n;
      pend_q   <= pend_n;
      if (upd) irq_o <= pend_n;
    end
  end

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sts |=> !irq_o);

  // R8
  ack_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sts && !status_q[S_BUSYN] && !ctrl_q[C_STB] && !status_q[S_ACK])
      |=> (status_q[S_ACK] && status_q[S_BUSYN]));

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && irq_o) |=> irq_o);
endmodule

// File: rtl/pp_data_path.sv
module pp_data_path
  import pp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_dat,
  input  logic wr_ctl,
  input  reg_t wdata,
  input  reg_t ctrl_q,
  input  logic rx_load,
  input  reg_t rx_byte,
  output reg_t dataw_q,
  output reg_t datar_q,
  output logic tx_valid,
  output reg_t tx_byte
);
  logic emit;

  assign emit = wr_ctl && wdata[C_INIT] && wdata[C_SEL] &&
                wdata[C_STB] && !ctrl_q[C_STB];

  always_ff @(posedge clk) begin
    if (rst) begin
      dataw_q  <= DATA_RST;
      datar_q  <= DATA_RST;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      if (wr_dat)  dataw_q <= wdata;
      if (rx_load) datar_q <= rx_byte;
      tx_valid <= emit;
      if (emit) tx_byte <= dataw_q;
    end
  end

  // R5
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
endmodule

// File: rtl/pp_regif.sv
module pp_regif
  import pp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_load,
  input  logic [REG_W-1:0]  rx_byte,
  output logic              tx_valid,
  output logic [REG_W-1:0]  tx_byte,
  output logic              irq
);
  logic [OFS_W-1:0] ofs;
  logic wr, rd, wr_dat, wr_ctl, rd_sts;
  reg_t ctrl_q, status_q, dataw_q, datar_q, rmux;

  assign ofs    = bus_addr[OFS_W-1:0];
  assign wr     = bus_en &  bus_we;
  assign rd     = bus_en & ~bus_we;
  assign wr_dat = wr && (ofs == OFS_DATA);
  assign wr_ctl = wr && (ofs == OFS_CTRL);
  assign rd_sts = rd && (ofs == OFS_STAT);

  pp_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctl), .wdata(bus_wdata), .ctrl_q(ctrl_q)
  );

  pp_status_seq u_stat (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_dat(wr_dat), .rd_sts(rd_sts),
    .new_ctl(bus_wdata), .ctrl_q(ctrl_q), .status_q(status_q), .irq_o(irq)
  );

  pp_data_path u_data (
    .clk(clk), .rst(rst), .wr_dat(wr_dat), .wr_ctl(wr_ctl),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .rx_load(rx_load), .rx_byte(rx_byte),
    .dataw_q(dataw_q), .datar_q(datar_q), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  always_comb begin
    case (ofs)
      OFS_DATA: rmux = ctrl_q[C_DIR] ? datar_q : dataw_q;
      OFS_STAT: rmux = status_q;
      OFS_CTRL: rmux = ctrl_q;
      default:  rmux = UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rmux;
  end

  // R2
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && ofs > OFS_CTRL) |=> (bus_rdata == UNMAPPED));

  // R5
  emit_state_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (!status_q[S_BUSYN] && ctrl_q[C_STB]));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_ctl));

  // R10
  nosel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && bus_wdata[C_INIT] && !bus_wdata[C_SEL]) |=> ($stable(status_q) && !tx_valid));
endmodule

// File: tb/tb_pp_regif.sv
module tb_pp_regif;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_load = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pp_regif #(.ADDR_W(4)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_load(rx_load),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  // {req, we, addr, wdata, expected read/tx byte, expected irq, expected tx_valid}
  localparam int NV = 31;
  localparam logic [26:0] VEC [NV] = '{
    {4'd1,  1'b0, 4'h2, 8'h00, 8'hCC, 1'b0, 1'b0}, // R1
    {4'd1,  1'b0, 4'h0, 8'h00, 8'hFF, 1'b0, 1'b0}, // R1
    {4'd1,  1'b0, 4'h1, 8'h00, 8'hD9, 1'b0, 1'b0}, // R1
    {4'd2,  1'b0, 4'h5, 8'h00, 8'hFF, 1'b0, 1'b0}, // R2
    {4'd2,  1'b0, 4'h7, 8'h00, 8'hFF, 1'b0, 1'b0}, // R2
    {4'd9,  1'b1, 4'h0, 8'h5A, 8'h00, 1'b0, 1'b0}, // R9
    {4'd9,  1'b0, 4'h0, 8'h00, 8'h5A, 1'b0, 1'b0}, // R9
    {4'd2,  1'b0, 4'h8, 8'h00, 8'h5A, 1'b0, 1'b0}, // R2
    {4'd2,  1'b0, 4'hA, 8'h00, 8'hCC, 1'b0, 1'b0}, // R2
    {4'd5,  1'b1, 4'h2, 8'h0D, 8'h5A, 1'b0, 1'b1}, // R5
    {4'd3,  1'b0, 4'h2, 8'h00, 8'hCD, 1'b0, 1'b0}, // R3
    {4'd5,  1'b0, 4'h1, 8'h00, 8'h59, 1'b0, 1'b0}, // R5
    {4'd6,  1'b1, 4'h2, 8'h1C, 8'h00, 1'b0, 1'b0}, // R6
    {4'd8,  1'b0, 4'h1, 8'h00, 8'h59, 1'b0, 1'b0}, // R8
    {4'd8,  1'b0, 4'h1, 8'h00, 8'h19, 1'b0, 1'b0}, // R8
    {4'd8,  1'b0, 4'h1, 8'h00, 8'hD9, 1'b0, 1'b0}, // R8
    {4'd6,  1'b1, 4'h2, 8'h1C, 8'h00, 1'b1, 1'b0}, // R6
    {4'd6,  1'b1, 4'h0, 8'h33, 8'h00, 1'b1, 1'b0}, // R6
    {4'd7,  1'b0, 4'h1, 8'h00, 8'hD9, 1'b0, 1'b0}, // R7
    {4'd5,  1'b1, 4'h2, 8'h1D, 8'h33, 1'b0, 1'b1}, // R5
    {4'd5,  1'b1, 4'h2, 8'h1D, 8'h00, 1'b0, 1'b0}, // R5
    {4'd5,  1'b0, 4'h1, 8'h00, 8'h59, 1'b0, 1'b0}, // R5
    {4'd10, 1'b1, 4'h2, 8'h15, 8'h00, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 4'h1, 8'h00, 8'h59, 1'b0, 1'b0}, // R10
    {4'd4,  1'b1, 4'h2, 8'h00, 8'h00, 1'b0, 1'b0}, // R4
    {4'd3,  1'b0, 4'h2, 8'h00, 8'hC0, 1'b0, 1'b0}, // R3
    {4'd4,  1'b0, 4'h1, 8'h00, 8'hD8, 1'b0, 1'b0}, // R4
    {4'd10, 1'b1, 4'h1, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 4'h1, 8'h00, 8'hD8, 1'b0, 1'b0}, // R10
    {4'd9,  1'b1, 4'h2, 8'h2C, 8'h00, 1'b0, 1'b0}, // R9
    {4'd9,  1'b0, 4'h0, 8'h00, 8'hFF, 1'b0, 1'b0}  // R9
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs right after reset
    chk(1, {7'd0, irq}, 8'd0, "irq after reset");
    chk(1, {7'd0, tx_valid}, 8'd0, "tx_valid after reset");

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      access(v[22], v[21:18], v[17:10]);
      if (!v[22]) chk(int'(v[26:23]), bus_rdata, v[9:2], "read data");
      chk(int'(v[26:23]), {7'd0, irq}, {7'd0, v[1]}, "irq level");
      chk(int'(v[26:23]), {7'd0, tx_valid}, {7'd0, v[0]}, "tx_valid");
      if (v[0]) chk(int'(v[26:23]), tx_byte, v[9:2], "tx byte");
    end

    // R11: input latch capture, direction still input
    @(negedge clk);
    rx_load = 1'b1; rx_byte = 8'h3C;
    @(negedge clk);
    rx_load = 1'b0;
    access(1'b0, 4'h0, 8'h00);
    chk(11, bus_rdata, 8'h3C, "input latch read");
    // R9: direction back to output returns written byte
    access(1'b1, 4'h2, 8'h0C);
    access(1'b0, 4'h0, 8'h00);
    chk(9, bus_rdata, 8'h33, "output byte read");

    // R1: reset in mid-run
    access(1'b1, 4'h0, 8'hA5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(1, {7'd0, irq}, 8'd0, "irq after second reset");
    access(1'b0, 4'h2, 8'h00);
    chk(1, bus_rdata, 8'hCC, "control after second reset");
    access(1'b0, 4'h1, 8'h00);
    chk(1, bus_rdata, 8'hD9, "status after second reset");
    access(1'b0, 4'h0, 8'h00);
    chk(1, bus_rdata, 8'hFF, "data after second reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule